// File: doc/BRIEF.md
# Register Write Guard with Two-Key Unlock

This block sits between a host register-access port and a register file. It passes every access straight through in the same cycle, except writes aimed at a protected address window. Those writes are refused until the host has written a two-byte key to a dedicated key register. The key register is not stored in the register file. The guard owns it: writes to it drive the lock state machine, and reads of it return the current lock status. The status comes back through the same one-cycle read-response path that carries register-file data.

Unlocking takes a write of 0xBA to the key address, followed by a write of 0xBE to the key address as the very next valid access. Cycles with no valid access may come between the two writes. After unlock, the window accepts writes until a byte other than 0xBA is written to the key address. A write into the window while locked is dropped silently. The guard flags it with a single-cycle error pulse.

Top module: `wp_guard`

## Requirements
- R1: After reset the guard is locked with no key stage pending, all outputs are low, and a read of address 0x10 returns 0x00.
- R2: A read of any address other than 0x10 is forwarded downstream in the same cycle with the address unchanged, whatever the lock state. rsp_valid is high in the next cycle, and rsp_rdata then carries rf_rdata.
- R3: A read of 0x10 is not forwarded downstream. In the next cycle rsp_valid is high and rsp_rdata is 0x01 if the guard was unlocked when the read was presented, or 0x00 if it was locked.
- R4: A write to 0x10 is never forwarded downstream.
- R5: A write of 0xBA to 0x10 followed, as the next valid access, by a write of 0xBE to 0x10 unlocks the guard from the following cycle. Idle cycles between the two writes are allowed.
- R6: Any valid access that follows a write of 0xBA to 0x10 and is not a write of 0xBE to 0x10 cancels the pending first key stage. This includes reads of any address. A write of 0xBA to 0x10 cancels the stage and immediately starts a new one.
- R7: A write to 0x10 of any byte other than 0xBA that does not complete the key sequence leaves the guard locked. This includes 0xBE when no first stage is pending. If the guard was unlocked, that write locks it.
- R8: A write of 0xBA to 0x10 while unlocked keeps the guard unlocked and starts a first key stage.
- R9: While locked, a write to an address in 0x11..0x27 is not forwarded downstream. wr_err is high in the following cycle, for that one cycle only.
- R10: While unlocked, a write into 0x11..0x27 is forwarded unchanged and raises no error.
- R11: A write to an address outside 0x10..0x27 is forwarded unchanged in the same cycle with no error, whatever the lock state.
- R12: Addresses 0x11 and 0x27 are inside the protected window. Addresses 0x0F and 0x28 are outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host access valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Host register address |
| req_wdata | input | 8 | Host write data |
| reg_valid | output | 1 | Access forwarded to the register file |
| reg_write | output | 1 | Forwarded access is a write |
| reg_addr | output | 7 | Forwarded address |
| reg_wdata | output | 8 | Forwarded write data |
| rf_rdata | input | 8 | Register file read data, valid the cycle after a forwarded read |
| rsp_valid | output | 1 | Read response valid, one cycle after any read |
| rsp_rdata | output | 8 | Read response data |
| wr_err | output | 1 | Single-cycle pulse after a refused protected write |

## Verification
The bench targets sequences that break the key stage. These are a read between the two key writes, a write to an open address between them, and a repeated 0xBA. A guard that armed on any access, or kept the stage across other traffic, would unlock where it must stay locked. It also writes 0xBE with no stage pending while unlocked, and writes 0xBA while unlocked. These catch a design that ignores the relock byte or drops the unlocked state on a re-arm. The window edges 0x11, 0x27, 0x0F and 0x28 are written while locked and read back. This exposes an off-by-one in the range decode as a changed or unchanged register value. Every refused write must produce exactly one wr_err cycle, so a stretched or missing pulse shows up in the scoreboard.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Class of an address seen by the guard
  typedef enum logic [1:0] {
    CLS_OPEN    = 2'd0,
    CLS_KEY     = 2'd1,
    CLS_GUARDED = 2'd2
  } addr_cls_e;

  // Classify an address against the key register and the protected window
  function automatic addr_cls_e classify(input logic [31:0] a,
                                         input logic [31:0] key,
                                         input logic [31:0] lo,
                                         input logic [31:0] hi);
    if (a == key)
      return CLS_KEY;
    else if (a >= lo && a <= hi)
      return CLS_GUARDED;
    else
      return CLS_OPEN;
  endfunction

  // True when a write to the key register carries the given byte
  function automatic logic key_byte_hit(input logic hit_key_wr,
                                        input logic [31:0] data,
                                        input logic [31:0] want);
    return hit_key_wr && (data == want);
  endfunction

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
  import wp_pkg::*;
#(
  parameter int AW       = 7,
  parameter int KEY_ADDR = 'h10,
  parameter int WIN_LO   = 'h11,
  parameter int WIN_HI   = 'h27
) (
  input  logic [AW-1:0] addr,
  output addr_cls_e     cls
);
  always_comb begin
    cls = classify(32'(addr), 32'(KEY_ADDR), 32'(WIN_LO), 32'(WIN_HI));
  end
endmodule

// File: rtl/wp_unlock_fsm.sv
module wp_unlock_fsm
  import wp_pkg::*;
#(
  parameter int DW       = 8,
  parameter int KEY_ARM  = 'hBA,
  parameter int KEY_OPEN = 'hBE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  addr_cls_e     acc_cls,
  input  logic [DW-1:0] acc_wdata,
  output logic          unlocked,
  output logic          armed
);
  logic unlocked_q, armed_q;
  logic hit_key_wr;
  logic take_arm, take_open, take_relock;

  always_comb begin
    hit_key_wr  = acc_valid && acc_write && (acc_cls == CLS_KEY);
    take_arm    = key_byte_hit(hit_key_wr, 32'(acc_wdata), 32'(KEY_ARM));
    take_open   = armed_q && key_byte_hit(hit_key_wr, 32'(acc_wdata), 32'(KEY_OPEN));
    // Any byte other than the arm byte that is not a completing open byte re-locks
    take_relock = hit_key_wr && !take_arm && !take_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      // Every valid access decides the stage afresh; idle cycles keep it
      if (acc_valid)
        armed_q <= take_arm;
      if (take_open)
        unlocked_q <= 1'b1;
      else if (take_relock)
        unlocked_q <= 1'b0;
    end
  end

  assign unlocked = unlocked_q;
  assign armed    = armed_q;
endmodule

// File: rtl/wp_access_gate.sv
module wp_access_gate
  import wp_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  addr_cls_e     cls,
  input  logic          unlocked,
  input  logic [DW-1:0] rf_rdata,
  output logic          reg_valid,
  output logic          reg_write,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          wr_err
);
  logic blocked, rd_any, rd_key;
  logic rsp_q, key_q, err_q;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] stat_now;

  always_comb begin
    blocked   = req_valid && req_write && (cls == CLS_GUARDED) && !unlocked;
    rd_any    = req_valid && !req_write;
    rd_key    = rd_any && (cls == CLS_KEY);
    stat_now  = {{(DW-1){1'b0}}, unlocked};
    reg_valid = req_valid && (cls != CLS_KEY) && !blocked;
    reg_write = req_write;
    reg_addr  = req_addr;
    reg_wdata = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      key_q  <= 1'b0;
      err_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      rsp_q  <= rd_any;
      key_q  <= rd_key;
      err_q  <= blocked;
      stat_q <= stat_now;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = !rsp_q ? '0 : (key_q ? stat_q : rf_rdata);
  assign wr_err    = err_q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int KEY_ADDR = 'h10,
  parameter int WIN_LO   = 'h11,
  parameter int WIN_HI   = 'h27,
  parameter int KEY_ARM  = 'hBA,
  parameter int KEY_OPEN = 'hBE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          reg_valid,
  output logic          reg_write,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          wr_err
);
  addr_cls_e cls_w;
  logic      unlocked_w;
  logic      armed_w;

  wp_addr_decode #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_dec (
    .addr (req_addr),
    .cls  (cls_w)
  );

  wp_unlock_fsm #(
    .DW(DW), .KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (req_valid),
    .acc_write (req_write),
    .acc_cls   (cls_w),
    .acc_wdata (req_wdata),
    .unlocked  (unlocked_w),
    .armed     (armed_w)
  );

  wp_access_gate #(
    .AW(AW), .DW(DW)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cls       (cls_w),
    .unlocked  (unlocked_w),
    .rf_rdata  (rf_rdata),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .wr_err    (wr_err)
  );
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int KEY_ADDR = 'h10,
  parameter int WIN_LO   = 'h11,
  parameter int WIN_HI   = 'h27,
  parameter int KEY_ARM  = 'hBA,
  parameter int KEY_OPEN = 'hBE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          reg_valid,
  input logic          reg_write,
  input logic [AW-1:0] reg_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          wr_err,
  input logic          unlocked,
  input logic          armed
);
  logic at_key, in_win, key_wr, bad_wr;
  assign at_key = (32'(req_addr) == 32'(KEY_ADDR));
  assign in_win = (32'(req_addr) >= 32'(WIN_LO)) && (32'(req_addr) <= 32'(WIN_HI));
  assign key_wr = req_valid && req_write && at_key;
  assign bad_wr = req_valid && req_write && in_win && !unlocked;

  // R9
  blocked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |-> !reg_valid);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err);
  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !wr_err);
  // R5
  unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(armed && key_wr && (32'(req_wdata) == 32'(KEY_OPEN))));
  // R6
  stage_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && req_valid && !(key_wr && (32'(req_wdata) == 32'(KEY_ARM)))) |=> !armed);
  // R3
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && !req_write && at_key)) |->
      (rsp_rdata == {{(DW-1){1'b0}}, $past(unlocked)}));
  // R4
  key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && at_key) |-> !reg_valid);
  // R2
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !at_key) |-> (reg_valid && !reg_write && reg_addr == req_addr));
  // R7
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !armed && (32'(req_wdata) != 32'(KEY_ARM))) |=> !unlocked);
  // R8
  arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr && (32'(req_wdata) == 32'(KEY_ARM))) |=> (unlocked && armed));
endmodule

bind wp_guard wp_guard_chk #(
  .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
  .KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .wr_err    (wr_err),
  .unlocked  (unlocked_w),
  .armed     (armed_w)
);

// File: tb/sim_wp_guard.sv
`timescale 1ns/1ps
module sim_wp_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       reg_valid, reg_write;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] rf_rdata = '0;
  logic       rsp_valid, wr_err;
  logic [7:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rf_rdata(rf_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_err(wr_err)
  );

  // Register file stub fed by the downstream port
  logic [7:0] stub [128];
  // Expected contents, kept by the bench model
  logic [7:0] exp_mem [128];
  initial begin
    for (int i = 0; i < 128; i++) begin
      stub[i]    = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
  end
  always @(posedge clk) begin
    if (reg_valid) begin
      if (reg_write) stub[reg_addr] <= reg_wdata;
      else           rf_rdata <= stub[reg_addr];
    end
  end

  // Scoreboard queues
  bit         q_err [$];
  logic [7:0] q_dat [$];
  string      q_tag [$];

  // Bench lock model
  bit m_unl = 0, m_arm = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [6:0] a, input logic [7:0] d, input string tag);
    bit key, prot, fwd;
    string dtag;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    key  = (a == 7'h10);
    prot = (a >= 7'h11) && (a <= 7'h27);
    fwd  = !key && !(w && prot && !m_unl);
    if (key)            dtag = w ? "R4" : "R3";
    else if (!w)        dtag = "R2";
    else if (prot)      dtag = m_unl ? "R10" : "R9";
    else                dtag = "R11";
    if (!w) begin
      q_err.push_back(0);
      q_dat.push_back(key ? {7'b0, m_unl} : exp_mem[a]);
      q_tag.push_back(tag);
    end else if (!fwd && !key) begin
      q_err.push_back(1);
      q_dat.push_back(8'h00);
      q_tag.push_back(tag);
    end
    #1;
    check(reg_valid == fwd, dtag, "reg_valid", 32'(reg_valid), 32'(fwd));
    if (fwd)
      check(reg_write == w && reg_addr == a && (!w || reg_wdata == d), dtag, "fwd fields",
            {reg_write, reg_addr, reg_wdata}, {w, a, w ? d : reg_wdata});
    // Model update
    if (fwd && w) exp_mem[a] = d;
    if (key && w) begin
      if (d == 8'hBA)               begin m_arm = 1; end
      else if (d == 8'hBE && m_arm) begin m_unl = 1; m_arm = 0; end
      else                          begin m_unl = 0; m_arm = 0; end
    end else begin
      m_arm = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 0;
    end
  endtask

  // Monitor: pops expected items as responses and error pulses appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && (rsp_valid || wr_err)) begin
        if (q_err.size() == 0) begin
          check(0, "R9", "unexpected output", {rsp_valid, wr_err}, 0);
        end else begin
          bit e; logic [7:0] dv; string t;
          e = q_err.pop_front(); dv = q_dat.pop_front(); t = q_tag.pop_front();
          check(wr_err == e && rsp_valid == !e, t, "kind", {rsp_valid, wr_err}, {!e, e});
          if (!e) check(rsp_rdata == dv, t, "rsp_rdata", rsp_rdata, dv);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_valid == 0 && rsp_valid == 0 && wr_err == 0, "R1", "reset outputs",
          {reg_valid, rsp_valid, wr_err}, 0);
    rst_n = 1;
    acc(0, 7'h10, 0, "R1");
    // R2 reads pass through
    acc(0, 7'h00, 0, "R2");
    acc(0, 7'h15, 0, "R2");
    acc(0, 7'h7F, 0, "R2");
    acc(0, 7'h30, 0, "R2");
    // R9 R12 blocked writes at window edges, R11 open edges
    acc(1, 7'h11, 8'h11, "R12");
    acc(1, 7'h27, 8'h27, "R12");
    acc(1, 7'h20, 8'h20, "R9");
    idle(1);
    acc(1, 7'h0F, 8'h3C, "R12");
    acc(1, 7'h28, 8'h4D, "R12");
    acc(1, 7'h50, 8'h5E, "R11");
    acc(0, 7'h11, 0, "R9");
    acc(0, 7'h27, 0, "R12");
    acc(0, 7'h0F, 0, "R11");
    acc(0, 7'h28, 0, "R12");
    // R5 unlock with idle gap
    acc(1, 7'h10, 8'hBA, "R5");
    idle(2);
    acc(1, 7'h10, 8'hBE, "R5");
    acc(0, 7'h10, 0, "R5");
    // R10 protected writes while unlocked
    acc(1, 7'h11, 8'h33, "R10");
    acc(1, 7'h27, 8'h44, "R10");
    acc(0, 7'h11, 0, "R10");
    acc(0, 7'h27, 0, "R10");
    // R8 arm while unlocked
    acc(1, 7'h10, 8'hBA, "R8");
    acc(0, 7'h10, 0, "R8");
    acc(1, 7'h10, 8'hBA, "R8");
    acc(1, 7'h10, 8'hBE, "R8");
    acc(0, 7'h10, 0, "R8");
    // R7 unpaired BE relocks
    acc(1, 7'h10, 8'hBE, "R7");
    acc(0, 7'h10, 0, "R7");
    acc(1, 7'h20, 8'h77, "R7");
    // R6 stage broken by a read
    acc(1, 7'h10, 8'hBA, "R6");
    acc(0, 7'h05, 0, "R6");
    acc(1, 7'h10, 8'hBE, "R6");
    acc(0, 7'h10, 0, "R6");
    // R6 stage broken by an open write
    acc(1, 7'h10, 8'hBA, "R6");
    acc(1, 7'h30, 8'h99, "R6");
    acc(1, 7'h10, 8'hBE, "R6");
    acc(1, 7'h12, 8'h88, "R6");
    // R6 repeated BA restarts the stage
    acc(1, 7'h10, 8'hBA, "R6");
    acc(1, 7'h10, 8'hBA, "R6");
    acc(1, 7'h10, 8'hBE, "R6");
    acc(0, 7'h10, 0, "R6");
    acc(1, 7'h12, 8'h66, "R10");
    // R7 other byte relocks
    acc(1, 7'h10, 8'h00, "R7");
    acc(0, 7'h10, 0, "R7");
    acc(1, 7'h12, 8'h55, "R9");
    acc(0, 7'h12, 0, "R9");
    acc(0, 7'h30, 0, "R11");
    idle(3);
    check(q_err.size() == 0, "R9", "scoreboard drained", q_err.size(), 0);
    finish_run();
  end
endmodule